// File: doc/BRIEF.md
# Pin I/O Port with Per-Pin Interrupt Detection

This block is a general-purpose pin port for a configurable number of pins, up to 32. Each pin has an output level, a direction bit and an interrupt detector. Software reaches the port through a 32-bit register interface. Each register is selected by a 3-bit word index, and that index corresponds to byte offsets 0x00 to 0x1C. Incoming pin levels pass through a two-stage synchroniser before they are read or examined for events.

Each pin's detector can be set to one of four triggers: high level, low level, rising edge or falling edge. One register chooses edge or level mode, and a second register chooses the polarity. Detected events latch into a raw status register whether or not they are enabled. The pending view is status masked by the enable register. A single summary interrupt output is raised whenever any bit is pending. Status bits are cleared by writing ones to the clear register. A pin cannot be set to trigger on both edges.

Top module: `gpio_irq_unit`

## Requirements
- R1: Word 1 (offset 0x04) holds direction, where a 1 makes the pin an input and a 0 makes it an output. `pin_oe` is the inverse of this register. Every direction bit resets to 1.
- R2: A write to word 0 (offset 0x00) sets `pin_out`, and the new level appears after the next rising clock edge. A read of word 0 returns the synchronised pin levels. A change on `pin_in` becomes visible there after two rising edges.
- R3: When a pin's mode bit (word 6, offset 0x18) is 0, the pin uses level detection. A polarity bit (word 7, offset 0x1C) of 1 makes a high level active, and 0 makes a low level active.
- R4: When a pin's mode bit is 1, the pin uses edge detection. A polarity bit of 0 triggers on a rising edge, and 1 triggers on a falling edge. An edge sets the status bit two clock edges after the synchroniser captures the change.
- R5: Status (word 3, offset 0x0C) latches every detected event whether or not it is enabled. A set bit stays set until it is cleared. Writes to word 3 have no effect.
- R6: Writing 1 to a bit of word 5 (offset 0x14) clears that pin's status bit, and writing 0 leaves it unchanged. A level that is still active, or an event that arrives in the same cycle as the clear, keeps the bit set.
- R7: The enable register (word 2, offset 0x08) resets to all zeros. Pending (word 4, offset 0x10) reads as status AND enable.
- R8: `irq_o` is high exactly when at least one pending bit is set.
- R9: Word 5 reads as zero. Bits at or above the configured pin count read as zero in every register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| pin_in | input | NPINS | External pin levels (asynchronous) |
| pin_out | output | NPINS | Driven output levels |
| pin_oe | output | NPINS | Output enable per pin |
| irq_o | output | 1 | Summary interrupt |

## Verification
Rising and falling edges are applied to pins set to opposite edge polarities. This shows that each pin responds only to its selected transition and ignores the other one. A pin in level mode is held at its active level while a clear is written, and is then switched between active-high and active-low. This separates sticky level re-assertion from a true clear. An edge is timed to arrive in the same cycle as a clear, which tells "new event wins" apart from "clear wins". Changes to the enable register show that raw status and the pending view differ only by the mask.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int BUS_W    = 32;
    localparam int MAX_PINS = 32;

    typedef enum logic [2:0] {
        W_LEVEL = 3'd0,
        W_DIR   = 3'd1,
        W_IEN   = 3'd2,
        W_STS   = 3'd3,
        W_PEND  = 3'd4,
        W_CLR   = 3'd5,
        W_MODE  = 3'd6,
        W_POL   = 3'd7
    } word_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] cur_o,
    output logic [NPINS-1:0] prev_o
);
    typedef struct packed {
        logic [NPINS-1:0] meta;
        logic [NPINS-1:0] cur;
        logic [NPINS-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = pin_in;
        sync_d.cur  = sync_q.meta;
        sync_d.prev = sync_q.cur;
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= sync_d;
    end

    assign cur_o  = sync_q.cur;
    assign prev_o = sync_q.prev;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
    parameter int NPINS = 24
) (
    input  logic [NPINS-1:0] cur,
    input  logic [NPINS-1:0] prev,
    input  logic [NPINS-1:0] mode,
    input  logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] evt
);
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic rise, fall, lvl;
        always_comb begin
            rise = cur[g] & ~prev[g];
            fall = ~cur[g] & prev[g];
            lvl  = pol[g] ? cur[g] : ~cur[g];
            if (mode[g]) evt[g] = pol[g] ? fall : rise;
            else         evt[g] = lvl;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [2:0]       bus_word,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] evt,
    output logic [NPINS-1:0] dout,
    output logic [NPINS-1:0] dir,
    output logic [NPINS-1:0] ien,
    output logic [NPINS-1:0] sts,
    output logic [NPINS-1:0] mode,
    output logic [NPINS-1:0] pol
);
    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] sts;
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] pol;
    } regs_t;

    regs_t            regs_d, regs_q;
    word_e            word;
    logic [NPINS-1:0] wd;
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] rd_w;
    logic             unused_hi;

    assign word      = word_e'(bus_word);
    assign wd        = bus_wdata[NPINS-1:0];
    assign unused_hi = ^bus_wdata;

    always_comb begin
        regs_d   = regs_q;
        clr_mask = '0;
        if (bus_sel && bus_we) begin
            case (word)
                W_LEVEL: regs_d.dout = wd;
                W_DIR:   regs_d.dir  = wd;
                W_IEN:   regs_d.ien  = wd;
                W_MODE:  regs_d.mode = wd;
                W_POL:   regs_d.pol  = wd;
                W_CLR:   clr_mask    = wd;
                default: ;
            endcase
        end
        regs_d.sts = (regs_q.sts & ~clr_mask) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q      <= '0;
            regs_q.dir  <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (word)
            W_LEVEL: rd_w = pin_lvl;
            W_DIR:   rd_w = regs_q.dir;
            W_IEN:   rd_w = regs_q.ien;
            W_STS:   rd_w = regs_q.sts;
            W_PEND:  rd_w = regs_q.sts & regs_q.ien;
            W_MODE:  rd_w = regs_q.mode;
            W_POL:   rd_w = regs_q.pol;
            default: rd_w = '0;
        endcase
    end

    assign bus_rdata = BUS_W'(rd_w);
    assign dout      = regs_q.dout;
    assign dir       = regs_q.dir;
    assign ien       = regs_q.ien;
    assign sts       = regs_q.sts;
    assign mode      = regs_q.mode;
    assign pol       = regs_q.pol;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [2:0]       bus_word,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq_o
);
    logic [NPINS-1:0] cur_w, prev_w, evt_w;
    logic [NPINS-1:0] dir_w, ien_w, sts_w, mode_w, pol_w;

    gpio_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .cur_o(cur_w), .prev_o(prev_w)
    );

    gpio_detect #(.NPINS(NPINS)) u_det (
        .cur(cur_w), .prev(prev_w), .mode(mode_w), .pol(pol_w), .evt(evt_w)
    );

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_lvl(cur_w), .evt(evt_w),
        .dout(pin_out), .dir(dir_w), .ien(ien_w), .sts(sts_w),
        .mode(mode_w), .pol(pol_w)
    );

    assign pin_oe = ~dir_w;
    assign irq_o  = |(sts_w & ien_w);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [2:0]       bus_word,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq_o,
    input logic [NPINS-1:0] sts,
    input logic [NPINS-1:0] ien,
    input logic [NPINS-1:0] evt
);
    logic wr_dir, wr_clr, rd_pend;
    assign wr_dir  = bus_sel && bus_we && (bus_word == W_DIR);
    assign wr_clr  = bus_sel && bus_we && (bus_word == W_CLR);
    assign rd_pend = bus_sel && !bus_we && (bus_word == W_PEND);

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> (pin_oe == ~$past(bus_wdata[NPINS-1:0]))); // R1

    AST_STS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_clr |=> (($past(sts) & ~sts) == '0)); // R5

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((sts & $past(evt)) == $past(evt))); // R5

    AST_CLR_BITS: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((sts & $past(bus_wdata[NPINS-1:0] & ~evt)) == '0)); // R6

    AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (rst)
        rd_pend |-> ((bus_rdata[NPINS-1:0] & ~sts) == '0)); // R7

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ien != '0)); // R8
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_oe(pin_oe), .irq_o(irq_o), .sts(sts_w), .ien(ien_w), .evt(evt_w)
);

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;
    localparam int NP = 24;
    localparam logic [31:0] MASK = 32'h00FF_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]    bus_word = 3'd0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_irq_unit #(.NPINS(NP)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    // Behavioural reference model, updated at each rising edge
    logic [31:0] m_dout, m_dir, m_ien, m_sts, m_mode, m_pol;
    logic [31:0] m_s1, m_s2, m_prev;

    function automatic logic [31:0] m_read(input int w);
        case (w)
            0: return m_s2;
            1: return m_dir;
            2: return m_ien;
            3: return m_sts;
            4: return m_sts & m_ien;
            6: return m_mode;
            7: return m_pol;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_dout = 0; m_dir = MASK; m_ien = 0; m_sts = 0;
            m_mode = 0; m_pol = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            logic [31:0] ev, clr, wd;
            ev = 0;
            for (int i = 0; i < NP; i++) begin
                if (m_mode[i]) ev[i] = m_pol[i] ? (m_prev[i] && !m_s2[i]) : (!m_prev[i] && m_s2[i]);
                else           ev[i] = (m_s2[i] == m_pol[i]);
            end
            wd  = bus_wdata & MASK;
            clr = (bus_sel && bus_we && bus_word == 3'd5) ? wd : 32'h0;
            m_sts = (m_sts & ~clr) | ev;
            if (bus_sel && bus_we) begin
                case (bus_word)
                    3'd0: m_dout = wd;
                    3'd1: m_dir  = wd;
                    3'd2: m_ien  = wd;
                    3'd6: m_mode = wd;
                    3'd7: m_pol  = wd;
                    default: ;
                endcase
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = {8'h0, pin_in};
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if ({8'h0, pin_out} != m_dout) begin
                errors++; $display("FAIL R2 pin_out act=%h exp=%h", pin_out, m_dout);
            end
            checks++;
            if ({8'h0, pin_oe} != (~m_dir & MASK)) begin
                errors++; $display("FAIL R1 pin_oe act=%h exp=%h", pin_oe, ~m_dir & MASK);
            end
            checks++;
            if (irq_o != |(m_sts & m_ien)) begin
                errors++; $display("FAIL R8 irq act=%b exp=%b", irq_o, |(m_sts & m_ien));
            end
            if (bus_sel && !bus_we) begin
                checks++;
                if (bus_rdata != m_read(int'(bus_word))) begin
                    errors++;
                    $display("FAIL R5/R7 model read word %0d act=%h exp=%h",
                             bus_word, bus_rdata, m_read(int'(bus_word)));
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_word = w; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd_chk(input logic [2:0] w, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 0; bus_word = w;
        @(negedge clk);
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s word %0d act=%h exp=%h", tag, w, bus_rdata, exp);
        end
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic out_chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++; $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk); #1;
        rst = 0;
        // Reset state
        rd_chk(3'd1, 32'h00FF_FFFF, "R1 dir reset");
        rd_chk(3'd2, 32'h0, "R7 enable reset");
        @(negedge clk); out_chk(irq_o, 1'b0, "R8 irq reset");
        // Direction and output level
        wr(3'd1, 32'h00FF_FF00);
        wr(3'd0, 32'h0000_00A5);
        @(negedge clk);
        checks++;
        if (pin_out != 24'h0000A5 || pin_oe != 24'h0000FF) begin
            errors++; $display("FAIL R1 R2 out act=%h/%h exp=0000a5/0000ff", pin_out, pin_oe);
        end
        // Synchronised pin read
        pin_in = 24'h123456; tick(4);
        rd_chk(3'd0, 32'h0012_3456, "R2 pin read");
        // Edge mode: pins 0..11 rising, 12..23 falling
        pin_in = '0; tick(4);
        wr(3'd6, 32'h00FF_FFFF);
        wr(3'd7, 32'h00FF_F000);
        wr(3'd5, 32'h00FF_FFFF);
        tick(2);
        rd_chk(3'd3, 32'h0, "R5 status after clear");
        pin_in = 24'h001001; tick(4);
        rd_chk(3'd3, 32'h0000_0001, "R4 rising only on rising pin");
        pin_in = 24'h000001; tick(4);
        rd_chk(3'd3, 32'h0000_1001, "R4 falling pin12");
        rd_chk(3'd4, 32'h0, "R7 pending masked");
        @(negedge clk); out_chk(irq_o, 1'b0, "R8 irq masked");
        // Enable pin 12
        wr(3'd2, 32'h0000_1000);
        rd_chk(3'd4, 32'h0000_1000, "R7 pending");
        @(negedge clk); out_chk(irq_o, 1'b1, "R8 irq set");
        // Clearing
        wr(3'd5, 32'h0000_0001);
        rd_chk(3'd3, 32'h0000_1000, "R6 clear one bit");
        wr(3'd5, 32'h0);
        rd_chk(3'd3, 32'h0000_1000, "R6 zero write no effect");
        wr(3'd5, 32'h0000_1000);
        @(negedge clk); out_chk(irq_o, 1'b0, "R8 irq after clear");
        // Level mode on pin 20, active high
        wr(3'd6, 32'h00EF_FFFF);
        tick(2);
        rd_chk(3'd3, 32'h0, "R3 level inactive");
        pin_in = 24'h100001; tick(4);
        rd_chk(3'd3, 32'h0010_0000, "R3 active high");
        wr(3'd5, 32'h0010_0000); tick(2);
        rd_chk(3'd3, 32'h0010_0000, "R6 level stays set");
        pin_in = 24'h000001; tick(4);
        wr(3'd5, 32'h0010_0000); tick(1);
        rd_chk(3'd3, 32'h0, "R6 clear after level gone");
        wr(3'd7, 32'h00EF_F000); tick(2);
        rd_chk(3'd3, 32'h0010_0000, "R3 active low");
        wr(3'd7, 32'h00FF_F000);
        wr(3'd5, 32'h0010_0000); tick(1);
        rd_chk(3'd3, 32'h0, "R3 restored polarity");
        // Event and clear in the same cycle: pin 1 rising
        @(posedge clk); #1; pin_in = 24'h000003;
        @(posedge clk);
        @(posedge clk); #1;
        bus_sel = 1; bus_we = 1; bus_word = 3'd5; bus_wdata = 32'h0000_0002;
        @(posedge clk); #1; bus_sel = 0; bus_we = 0;
        rd_chk(3'd3, 32'h0000_0002, "R6 event wins over clear");
        // Status write ignored, unused bits and clear word read zero
        wr(3'd3, 32'h0);
        rd_chk(3'd3, 32'h0000_0002, "R5 status write ignored");
        rd_chk(3'd5, 32'h0, "R9 clear word reads zero");
        wr(3'd1, 32'hFFFF_FFFF);
        rd_chk(3'd1, 32'h00FF_FFFF, "R9 upper bits zero");
        tick(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule